// File: doc/BRIEF.md
# Predicate First/Next Active Scanner

This block performs two scans over a predicate, where each bit stands for one byte lane of a vector. The *first-active* scan takes a destination predicate and a governing predicate and returns the destination with one extra bit set. That bit is the lowest set bit of the governing predicate. All other destination bits pass through unchanged.

The *next-active* scan acts as one step of an iterator over the active elements of the governing predicate. It finds the highest element-aligned set bit of the current destination. It then looks for the next element-aligned active bit of the governing predicate above that point and returns it as a one-hot predicate. When the destination holds no element-aligned bit, the search restarts at lane 0. When the search runs past the top, the result is all zeros.

Both scans also return four condition flags, N, Z, C and V, evaluated on the result against the governing predicate. A one-cycle `start` pulse launches a scan. The result and flags are registered on the next clock edge and then held until the next scan.

Top module: `pred_scan_unit`

## Requirements
- R1: The result, the flags and a one-cycle `done` pulse appear on the clock edge that samples `start` high. While `start` is low, the result and flags keep their values and `done` is 0.
- R2: For first-active (`op_sel`=0), the result is `dst_in` OR the lowest set bit of `gov_in`. When `gov_in` is zero, the result equals `dst_in`.
- R3: First-active ignores `elem_size`, and every bit of `gov_in` is a candidate.
- R4: For next-active (`op_sel`=1), the governing predicate is masked by element size before the search: `elem_size` 0, 1, 2 and 3 keep the bits whose index is a multiple of 1, 2, 4 and 8 respectively.
- R5: The next-active search begins one element (2^`elem_size` bits) above the highest set bit of `dst_in` at an element-aligned position. Non-aligned destination bits are ignored. With no aligned destination bit, the search begins at bit 0.
- R6: The next-active result has exactly one bit set, at the lowest qualifying position. It is all zeros when no position qualifies.
- R7: N is 1 exactly when the governing predicate is non-zero and the result has its lowest governing bit set.
- R8: Z is 1 exactly when the result has no set bit at a governing position.
- R9: C is 1 when the governing predicate is zero or the result lacks its highest governing bit. V is always 0.
- R10: For next-active, the flags use the element-size-masked governing predicate. For first-active, they use `gov_in` as given.
- R11: After reset, `done`, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a scan with the current inputs |
| op_sel | input | 1 | 0 = first-active, 1 = next-active |
| elem_size | input | 2 | Log2 of element size in bytes |
| dst_in | input | PW | Current destination predicate |
| gov_in | input | PW | Governing predicate |
| done | output | 1 | Result valid pulse |
| result | output | PW | Scan result predicate |
| flag_n | output | 1 | First governing bit set in result |
| flag_z | output | 1 | No governing bit set in result |
| flag_c | output | 1 | Last governing bit not set in result |
| flag_v | output | 1 | Always 0 |

## Verification
The only internal state is the output register. A wrong next value therefore appears at the ports on the first `done` after the faulty scan and never later. A wrong mask or start point in next-active shows up as a one-hot result that is misplaced or missing. Such an error usually also flips N or C, because both are derived from the same governing bits. A sweep over every governing pattern and every element size, with a range of destinations, reaches every priority position of the encoders within a few thousand scans.

// File: rtl/pred_scan_pkg.sv
package pred_scan_pkg;
    typedef enum logic {
        OP_FIRST = 1'b0,
        OP_NEXT  = 1'b1
    } scan_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } scan_flags_t;
endpackage

// File: rtl/pred_elem_mask.sv
module pred_elem_mask #(
    parameter int PW = 64
) (
    input  logic [1:0]    elem_size,
    output logic [PW-1:0] mask
);
    for (genvar i = 0; i < PW; i++) begin : g_bit
        always_comb begin
            case (elem_size)
                2'd0:    mask[i] = 1'b1;
                2'd1:    mask[i] = (i % 2) == 0;
                2'd2:    mask[i] = (i % 4) == 0;
                default: mask[i] = (i % 8) == 0;
            endcase
        end
    end
endmodule

// File: rtl/pred_bit_finder.sv
module pred_bit_finder #(
    parameter int PW     = 64,
    parameter bit LOWEST = 1'b1,
    localparam int IW    = (PW > 1) ? $clog2(PW) : 1
) (
    input  logic [PW-1:0] vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    assign found = |vec;

    if (LOWEST) begin : g_low
        always_comb begin
            idx = '0;
            for (int i = PW - 1; i >= 0; i--) begin
                if (vec[i]) idx = IW'(i);
            end
        end
    end else begin : g_high
        always_comb begin
            idx = '0;
            for (int i = 0; i < PW; i++) begin
                if (vec[i]) idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pred_scan_unit.sv
module pred_scan_unit
    import pred_scan_pkg::*;
#(
    parameter int PW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_sel,
    input  logic [1:0]    elem_size,
    input  logic [PW-1:0] dst_in,
    input  logic [PW-1:0] gov_in,
    output logic          done,
    output logic [PW-1:0] result,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic          flag_v
);
    localparam int IW = (PW > 1) ? $clog2(PW) : 1;
    localparam int SW = IW + 2;
    localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic        valid;
        logic [PW-1:0] res;
        scan_flags_t flags;
    } scan_state_t;

    scan_state_t state_d, state_q;
    scan_op_e    op;

    logic [PW-1:0] esz_mask, gov_masked, gov_sel, dst_aligned, cand;
    logic [SW-1:0] start_pos;
    logic          g_any, g_top_any, d_any, c_any;
    logic [IW-1:0] g_lo_idx, g_hi_idx, d_hi_idx, c_idx;

    assign op = scan_op_e'(op_sel);

    pred_elem_mask #(.PW(PW)) u_mask (
        .elem_size (elem_size),
        .mask      (esz_mask)
    );

    assign gov_masked  = gov_in & esz_mask;
    assign gov_sel     = (op == OP_NEXT) ? gov_masked : gov_in;
    assign dst_aligned = dst_in & esz_mask;

    pred_bit_finder #(.PW(PW), .LOWEST(1'b1)) u_gov_lo (
        .vec (gov_sel), .found (g_any), .idx (g_lo_idx)
    );
    pred_bit_finder #(.PW(PW), .LOWEST(1'b0)) u_gov_hi (
        .vec (gov_sel), .found (g_top_any), .idx (g_hi_idx)
    );
    pred_bit_finder #(.PW(PW), .LOWEST(1'b0)) u_dst_hi (
        .vec (dst_aligned), .found (d_any), .idx (d_hi_idx)
    );

    always_comb begin
        start_pos = '0;
        if (d_any) start_pos = SW'(d_hi_idx) + (SW'(1) << elem_size);
    end

    assign cand = gov_masked & ({PW{1'b1}} << start_pos);

    pred_bit_finder #(.PW(PW), .LOWEST(1'b1)) u_cand_lo (
        .vec (cand), .found (c_any), .idx (c_idx)
    );

    always_comb begin
        logic [PW-1:0] res;
        state_d = state_q;
        state_d.valid = start;
        if (op == OP_FIRST) begin
            res = dst_in | (g_any ? (ONE << g_lo_idx) : '0);
        end else begin
            res = c_any ? (ONE << c_idx) : '0;
        end
        if (start) begin
            state_d.res     = res;
            state_d.flags.n = g_any && res[g_lo_idx];
            state_d.flags.z = (res & gov_sel) == '0;
            state_d.flags.c = !g_top_any || !res[g_hi_idx];
            state_d.flags.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign done   = state_q.valid;
    assign result = state_q.res;
    assign flag_n = state_q.flags.n;
    assign flag_z = state_q.flags.z;
    assign flag_c = state_q.flags.c;
    assign flag_v = state_q.flags.v;
endmodule

// File: rtl/pred_scan_checker.sv
module pred_scan_checker #(
    parameter int PW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          op_sel,
    input logic [PW-1:0] dst_in,
    input logic [PW-1:0] gov_in,
    input logic          done,
    input logic [PW-1:0] result,
    input logic          flag_n,
    input logic          flag_z,
    input logic          flag_c,
    input logic          flag_v
);
    a_r1_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!done && $stable(result) && $stable(flag_z)));

    a_r2_first_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !op_sel) |=> ((result & $past(dst_in)) == $past(dst_in)));

    a_r6_next_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel) |=> $onehot0(result));

    a_r9_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_v);

    a_r9_empty_gov_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (start && gov_in == '0) |=> (flag_c && flag_z && !flag_n));
endmodule

bind pred_scan_unit pred_scan_checker #(.PW(PW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_sel (op_sel),
    .dst_in (dst_in),
    .gov_in (gov_in),
    .done   (done),
    .result (result),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .flag_v (flag_v)
);

// File: tb/pred_scan_unit_bench.sv
module pred_scan_unit_bench;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_sel = 1'b0;
    logic [1:0]    elem_size = 2'd0;
    logic [PW-1:0] dst_in = '0;
    logic [PW-1:0] gov_in = '0;
    logic          done;
    logic [PW-1:0] result;
    logic          flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pred_scan_unit #(.PW(PW)) u_pred_scan_unit (
        .clk (clk), .rst_n (rst_n), .start (start), .op_sel (op_sel),
        .elem_size (elem_size), .dst_in (dst_in), .gov_in (gov_in),
        .done (done), .result (result), .flag_n (flag_n), .flag_z (flag_z),
        .flag_c (flag_c), .flag_v (flag_v)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference computed from the requirements.
    task automatic model(input bit op, input logic [1:0] esz, input logic [PW-1:0] d,
                         input logic [PW-1:0] g, output logic [PW-1:0] r, output logic [3:0] f);
        logic [PW-1:0] m, gg;
        int st, fi, li, step;
        bit n, z, c;
        step = 1 << esz;
        for (int i = 0; i < PW; i++) m[i] = (i % step) == 0;
        r = '0;
        if (!op) begin
            gg = g;  // R3: no element mask for first-active
            r = d;
            for (int i = PW - 1; i >= 0; i--) if (g[i]) fi = i;
            if (g != '0) r[fi] = 1'b1;
        end else begin
            gg = g & m;  // R4, R10
            st = 0;
            for (int i = 0; i < PW; i++) if (d[i] && m[i]) st = i + step;  // R5
            for (int i = PW - 1; i >= 0; i--) if (i >= st && gg[i]) begin
                r = '0; r[i] = 1'b1;  // R6
            end
        end
        n = 0; z = 1; c = 1;
        if (gg != '0) begin
            fi = 0; li = 0;
            for (int i = PW - 1; i >= 0; i--) if (gg[i]) fi = i;
            for (int i = 0; i < PW; i++) if (gg[i]) li = i;
            n = r[fi];
            c = !r[li];
            z = (r & gg) == '0;
        end
        f = {n, z, c, 1'b0};
    endtask

    task automatic run_op(input bit op, input logic [1:0] esz, input logic [PW-1:0] d, input logic [PW-1:0] g);
        logic [PW-1:0] er;
        logic [3:0] ef, af;
        @(negedge clk);
        op_sel = op; elem_size = esz; dst_in = d; gov_in = g; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model(op, esz, d, g, er, ef);
        af = {flag_n, flag_z, flag_c, flag_v};
        check(done === 1'b1, "R1 done pulse", 16'(done), 16'h1);
        if (!op) check(result === er, "R2 R3 first-active result", 16'(result), 16'(er));
        else     check(result === er, "R4 R5 R6 next-active result", 16'(result), 16'(er));
        check(af[3] === ef[3], "R7 N flag", 16'(af[3]), 16'(ef[3]));
        check(af[2] === ef[2], "R8 Z flag (R10)", 16'(af[2]), 16'(ef[2]));
        check(af[1:0] === ef[1:0], "R9 C/V flags", 16'(af[1:0]), 16'(ef[1:0]));
    endtask

    initial begin
        #200000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done === 1'b0 && result === '0, "R11 reset done/result", {7'd0, done, result}, 16'h0);
        check({flag_n, flag_z, flag_c, flag_v} === 4'h0, "R11 reset flags",
              16'({flag_n, flag_z, flag_c, flag_v}), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners.
        run_op(1'b0, 2'd0, 8'h00, 8'h00);  // R2 empty governing
        run_op(1'b0, 2'd3, 8'h10, 8'h0C);  // R3 esz ignored
        run_op(1'b1, 2'd1, 8'h02, 8'hFF);  // R5 unaligned dst -> restart at 0
        run_op(1'b1, 2'd0, 8'h80, 8'hFF);  // R6 run off end -> zero
        run_op(1'b1, 2'd2, 8'h01, 8'h11);  // R4 step to bit 4

        // R1: outputs hold while idle.
        begin
            logic [PW-1:0] held;
            held = result;
            repeat (3) @(negedge clk);
            check(done === 1'b0, "R1 no done while idle", 16'(done), 16'h0);
            check(result === held, "R1 result held", 16'(result), 16'(held));
        end

        // Sweep: every governing pattern, every size, both ops, spread of dst.
        for (int g = 0; g < 256; g++) begin
            for (int k = 0; k < 16; k++) begin
                for (int e = 0; e < 4; e++) begin
                    run_op(1'b1, 2'(e), 8'((k * 37 + g) & 8'hFF) & 8'(k * 17), 8'(g));
                end
                run_op(1'b0, 2'(k), 8'(k * 17), 8'(g));
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule